// File: doc/BRIEF.md
# Subcarrier Tag Response Encoder

This block sends a tag's answer back to a reader over a vicinity-card style inductive link. It runs on the carrier clock (nominally 13.56 MHz). It takes the response one byte at a time over a valid/ready interface, where the first byte carries a start marker and the final byte carries a last marker. It turns the frame into a stream of half-bits and drives a load-modulation output from that stream.

The frame opens with a fixed eight-half-bit start pattern. Each data bit follows as a pair of half-bits, least significant bit first. The frame closes with a fixed eight-half-bit end pattern, which the block adds on its own. A half-bit of 1 is a burst of subcarrier pulses at one thirty-second of the carrier frequency, and a half-bit of 0 is an unmodulated interval of the same length. With the default parameters a half-bit is 256 carrier cycles (about 18.88 us) and holds eight pulses.

The pulse half-period, the number of pulses per half-bit, the byte width and the polarity of the modulation output are all parameters.

Top module: `subcarrier_resp_enc`

## Requirements
- R1: After synchronous reset, `mod_out` is at its unmodulated level (low in the default active-high variant), `busy` is low and `in_ready` is high.
- R2: A frame starts with the start pattern. Its half-bits in time order are 0,0,0,1,1,1,0,1, and each lasts HB = 2·SUB_HALF·PULSES carrier cycles.
- R3: Each data bit is sent least significant bit first. A bit of 1 becomes half-bits 0 then 1, and a bit of 0 becomes half-bits 1 then 0.
- R4: During a half-bit of 1, `mod_out` is high for SUB_HALF cycles and then low for SUB_HALF cycles, repeated PULSES times, starting high. During a half-bit of 0 it stays low for all HB cycles.
- R5: After the byte marked last, the end pattern follows at once. Its half-bits in time order are 1,0,1,1,1,0,0,0.
- R6: Consecutive bytes of a frame are sent with no gap. `in_ready` is high only while idle, or in the final carrier cycle of a data byte's last half-bit when that byte was not marked last.
- R7: `busy` rises in the first cycle of the start pattern and stays high through the final cycle of the end pattern. It is low in the cycle after that.
- R8: While idle, a byte offered without the start marker is consumed and ignored. No frame starts, and `busy` and `mod_out` stay low.
- R9: If no byte is offered when a non-last byte finishes, the end pattern is sent right after it, just as if that byte had been marked last.
- R10: The first byte is taken in the cycle it is offered while idle. The start pattern's first half-bit begins on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte offered |
| in_data | input | DATA_W | Response byte, sent LSB first |
| in_first | input | 1 | Marks the first byte of a frame |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Byte accepted at this edge when valid |
| busy | output | 1 | Frame in progress |
| mod_out | output | 1 | Load-modulation drive |

## Verification
The properties assume that the sender keeps `in_first` for the opening byte and drives every byte of a frame before the current byte runs out, except when it is testing an underrun on purpose. The bench drives inputs only on falling edges. It offers each next byte in the cycle after the previous one is taken, holds it until `in_ready` is seen, and releases all inputs after the final byte. The assertions rely on SUB_HALF being at least 2, so that every pulse lasts more than one cycle. They also rely on the start and end patterns beginning and ending on an unmodulated half-bit.

// File: rtl/resp_enc_pkg.sv
package resp_enc_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_SOF, ST_DATA, ST_EOF} frame_st_e;
   // framing patterns, most significant half-bit leaves first
   localparam logic [7:0] SOF_HB  = 8'b0001_1101;
   localparam logic [7:0] EOF_HB  = 8'b1011_1000;
   localparam int unsigned MARK_HB = 8;
endpackage

// File: rtl/resp_halfbit_timer.sv
module resp_halfbit_timer #(
   parameter int unsigned SUB_HALF = 16,
   parameter int unsigned PULSES   = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic hb_last,
   output logic sc_on
);
   localparam int unsigned HB_CYC = 2 * SUB_HALF * PULSES;
   localparam int unsigned TW     = $clog2(HB_CYC);
   localparam int unsigned SH_W   = $clog2(SUB_HALF);

   logic [TW-1:0] tcnt;

   always_ff @(posedge clk) begin
      if (rst || !run)  tcnt <= '0;
      else if (hb_last) tcnt <= '0;
      else              tcnt <= tcnt + 1'b1;
   end

   assign hb_last = run && (tcnt == TW'(HB_CYC - 1));
   // pulse phase: high in the first SUB_HALF cycles of each period
   assign sc_on   = ~tcnt[SH_W];
endmodule

// File: rtl/resp_bit_coder.sv
module resp_bit_coder #(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0]   data,
   output logic [2*DATA_W-1:0] code
);
   localparam int unsigned CODE_W = 2 * DATA_W;

   // bit i lands in the i-th pair from the top, so LSB leaves first
   for (genvar i = 0; i < DATA_W; i++) begin : g_pair
      assign code[CODE_W-1-2*i -: 2] = data[i] ? 2'b01 : 2'b10;
   end
endmodule

// File: rtl/resp_frame_seq.sv
module resp_frame_seq
   import resp_enc_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                hb_last,
   input  logic                in_valid,
   input  logic                in_first,
   input  logic                in_last,
   input  logic [2*DATA_W-1:0] in_code,
   output logic                in_ready,
   output logic                busy,
   output logic                hb_value
);
   localparam int unsigned CODE_W = 2 * DATA_W;
   localparam int unsigned CNT_W  = $clog2(CODE_W + 1);
   localparam int unsigned PAD_W  = CODE_W - MARK_HB;
   localparam logic [CNT_W-1:0]  CNT_CODE = CNT_W'(CODE_W);
   localparam logic [CNT_W-1:0]  CNT_MARK = CNT_W'(MARK_HB);
   localparam logic [CODE_W-1:0] SOF_WORD = CODE_W'(SOF_HB) << PAD_W;
   localparam logic [CODE_W-1:0] EOF_WORD = CODE_W'(EOF_HB) << PAD_W;

   frame_st_e         st;
   logic [CODE_W-1:0] shreg;
   logic [CODE_W-1:0] pend_code;
   logic [CNT_W-1:0]  left;
   logic              pend_last;
   logic              cur_last;
   logic              word_end;

   assign word_end = hb_last && (left == CNT_W'(1));
   assign in_ready = (st == ST_IDLE) || ((st == ST_DATA) && word_end && !cur_last);
   assign busy     = (st != ST_IDLE);
   assign hb_value = shreg[CODE_W-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= ST_IDLE;
         shreg     <= '0;
         pend_code <= '0;
         left      <= '0;
         pend_last <= 1'b0;
         cur_last  <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (in_valid && in_first) begin
                  shreg     <= SOF_WORD;
                  left      <= CNT_MARK;
                  pend_code <= in_code;
                  pend_last <= in_last;
                  st        <= ST_SOF;
               end
            end
            ST_SOF: begin
               if (word_end) begin
                  shreg    <= pend_code;
                  left     <= CNT_CODE;
                  cur_last <= pend_last;
                  st       <= ST_DATA;
               end else if (hb_last) begin
                  shreg <= shreg << 1;
                  left  <= left - 1'b1;
               end
            end
            ST_DATA: begin
               if (word_end) begin
                  if (!cur_last && in_valid) begin
                     shreg    <= in_code;
                     left     <= CNT_CODE;
                     cur_last <= in_last;
                  end else begin
                     shreg <= EOF_WORD;
                     left  <= CNT_MARK;
                     st    <= ST_EOF;
                  end
               end else if (hb_last) begin
                  shreg <= shreg << 1;
                  left  <= left - 1'b1;
               end
            end
            ST_EOF: begin
               if (word_end) begin
                  shreg <= '0;
                  left  <= '0;
                  st    <= ST_IDLE;
               end else if (hb_last) begin
                  shreg <= shreg << 1;
                  left  <= left - 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/resp_mod_drive.sv
module resp_mod_drive #(
   parameter bit ACTIVE_HIGH = 1'b1
) (
   input  logic busy,
   input  logic hb_value,
   input  logic sc_on,
   output logic mod_out
);
   logic level;
   assign level = busy & hb_value & sc_on;

   if (ACTIVE_HIGH) begin : g_hi
      assign mod_out = level;
   end else begin : g_lo
      assign mod_out = ~level;
   end
endmodule

// File: rtl/subcarrier_resp_enc.sv
module subcarrier_resp_enc #(
   parameter int unsigned DATA_W          = 8,
   parameter int unsigned SUB_HALF        = 16,
   parameter int unsigned PULSES          = 8,
   parameter bit          MOD_ACTIVE_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_first,
   input  logic              in_last,
   output logic              in_ready,
   output logic              busy,
   output logic              mod_out
);
   if (SUB_HALF < 2 || (SUB_HALF & (SUB_HALF - 1)) != 0) begin : g_bad_sub
      $error("SUB_HALF must be a power of two of at least 2");
   end
   if (PULSES < 1) begin : g_bad_pulses
      $error("PULSES must be at least 1");
   end
   if (DATA_W < 4) begin : g_bad_width
      $error("DATA_W must be at least 4");
   end

   logic hb_last, sc_on, hb_value;
   logic [2*DATA_W-1:0] in_code;

   resp_bit_coder #(.DATA_W(DATA_W)) u_coder (
      .data (in_data),
      .code (in_code)
   );

   resp_halfbit_timer #(.SUB_HALF(SUB_HALF), .PULSES(PULSES)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .run     (busy),
      .hb_last (hb_last),
      .sc_on   (sc_on)
   );

   resp_frame_seq #(.DATA_W(DATA_W)) u_seq (
      .clk      (clk),
      .rst      (rst),
      .hb_last  (hb_last),
      .in_valid (in_valid),
      .in_first (in_first),
      .in_last  (in_last),
      .in_code  (in_code),
      .in_ready (in_ready),
      .busy     (busy),
      .hb_value (hb_value)
   );

   resp_mod_drive #(.ACTIVE_HIGH(MOD_ACTIVE_HIGH)) u_drive (
      .busy     (busy),
      .hb_value (hb_value),
      .sc_on    (sc_on),
      .mod_out  (mod_out)
   );
endmodule

// File: rtl/resp_enc_checker.sv
module resp_enc_checker #(
   parameter bit ACT_HIGH = 1'b1
) (
   input logic clk,
   input logic rst,
   input logic in_valid,
   input logic in_first,
   input logic in_ready,
   input logic busy,
   input logic mod_out
);
   logic lvl;
   assign lvl = ACT_HIGH ? mod_out : ~mod_out;

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      !busy |-> !lvl);
   assert_sof_opens_quiet_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> !lvl);
   assert_pulse_width_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(lvl) |=> lvl);
   assert_eof_closes_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> !$past(lvl));
   assert_ready_midframe_R6: assert property (@(posedge clk) disable iff (rst)
      (in_ready && busy) |=> busy);
   assert_no_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
      (!busy && in_valid && !in_first) |=> !busy);
   assert_start_taken_R10: assert property (@(posedge clk) disable iff (rst)
      (!busy && in_valid && in_first) |=> busy);
endmodule

bind subcarrier_resp_enc resp_enc_checker #(.ACT_HIGH(MOD_ACTIVE_HIGH)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .in_first (in_first),
   .in_ready (in_ready),
   .busy     (busy),
   .mod_out  (mod_out)
);

// File: tb/sim_subcarrier_resp_enc.sv
module sim_subcarrier_resp_enc;
   localparam int CLK_PERIOD = 10;
   localparam int DW  = 8;
   localparam int SH  = 4;
   localparam int NP  = 2;
   localparam int HB  = 2 * SH * NP;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic in_first = 1'b0;
   logic in_last = 1'b0;
   logic in_ready, busy, mod_out;

   int checks = 0;
   int errors = 0;

   logic [DW-1:0] tx_bytes [0:7];
   logic          exp_hb [0:255];
   int            exp_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   subcarrier_resp_enc #(.DATA_W(DW), .SUB_HALF(SH), .PULSES(NP)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_first(in_first), .in_last(in_last), .in_ready(in_ready),
      .busy(busy), .mod_out(mod_out)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic push_hb(input logic v);
      exp_hb[exp_n] = v;
      exp_n++;
   endtask

   // R2 start pattern, R3 bit pairs LSB first, R5 end pattern
   task automatic build_expected(input int nb);
      logic [7:0] sof = 8'b0001_1101;
      logic [7:0] eof = 8'b1011_1000;
      exp_n = 0;
      for (int i = 7; i >= 0; i--) push_hb(sof[i]);
      for (int b = 0; b < nb; b++)
         for (int i = 0; i < DW; i++) begin
            push_hb(!tx_bytes[b][i]);
            push_hb(tx_bytes[b][i]);
         end
      for (int i = 7; i >= 0; i--) push_hb(eof[i]);
   endtask

   task automatic drive(input int nb, input bit mark_last);
      @(negedge clk);
      for (int b = 0; b < nb; b++) begin
         in_valid = 1'b1;
         in_data  = tx_bytes[b];
         in_first = (b == 0);
         in_last  = mark_last && (b == nb - 1);
         while (!in_ready) @(negedge clk);
         @(negedge clk);
      end
      in_valid = 1'b0;
      in_first = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic watch(input string tag);
      int guard = 0;
      @(negedge clk);
      while (!busy && guard < 10) begin
         @(negedge clk);
         guard++;
      end
      // R10: busy one cycle after the offer made at the first falling edge
      check({tag, " R10 start latency"}, logic'(guard == 1), 1'b1);
      for (int h = 0; h < exp_n; h++)
         for (int k = 0; k < HB; k++) begin
            check({tag, " R2/R3/R5 R4 mod_out"}, mod_out,
                  exp_hb[h] && ((k / SH) % 2 == 0));
            check({tag, " R7 busy"}, busy, 1'b1);
            if (h < 8) check({tag, " R6 ready low in start"}, in_ready, 1'b0);
            @(negedge clk);
         end
      check({tag, " R7 busy low after end"}, busy, 1'b0);
      check({tag, " R1 idle mod_out"}, mod_out, 1'b0);
      check({tag, " R6 ready back"}, in_ready, 1'b1);
   endtask

   task automatic play(input int nb, input bit mark_last, input string tag);
      build_expected(nb);
      fork
         drive(nb, mark_last);
         watch(tag);
      join
   endtask

   task automatic t_reset;
      check("R1 reset mod_out", mod_out, 1'b0);
      check("R1 reset busy", busy, 1'b0);
      check("R1 reset ready", in_ready, 1'b1);
   endtask

   task automatic t_single;
      tx_bytes[0] = 8'h01;
      play(1, 1'b1, "single 0x01");
   endtask

   task automatic t_multi;
      tx_bytes[0] = 8'hA5;
      tx_bytes[1] = 8'h00;
      tx_bytes[2] = 8'hFF;
      tx_bytes[3] = 8'h3C;
      play(4, 1'b1, "multi R6 back-to-back");
   endtask

   task automatic t_no_start;
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'h77;
      in_first = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      for (int i = 0; i < 3 * HB; i++) begin
         check("R8 busy stays low", busy, 1'b0);
         check("R8 mod_out stays low", mod_out, 1'b0);
         @(negedge clk);
      end
   endtask

   task automatic t_underrun;
      tx_bytes[0] = 8'h96;
      play(1, 1'b0, "underrun R9");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_single();
      t_multi();
      t_no_start();
      t_underrun();
      repeat (4) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule